// File: doc/BRIEF.md
# Poison Tag Tracker

This block keeps one deferred-exception tag bit for every architectural register. It applies the tag rules that let an in-order core hoist instructions above branches without turning a harmless speculative fault into a crash. Each cycle, at most one retiring instruction is presented as a descriptor. The descriptor gives two source register numbers, a destination number with a write enable, and four flags: speculative, exception-occurred, store and check. The block reads the tags of the sources, decides the outcome, and updates the destination tag in the same clock edge.

A speculative instruction never faults. Instead, its destination becomes tagged when it hit a terminating exception itself or when it consumed a tagged value. Two kinds of instruction do raise a fault request: a non-speculative consumer of a tagged value, and a store, since memory holds no tags. A check instruction that finds its register tagged raises a branch-to-recovery request. Each request is a one-cycle pulse in the cycle after the instruction is accepted and carries the offending register number. The data values and the handler that services the requests belong to the surrounding core.

Top module: `poison_tracker`

## Requirements
- R1: While `rst_n` is low, every tag and both request outputs are 0. After `rst_n` rises, the block accepts instructions from the third rising clock edge on.
- R2: A speculative, non-store, non-check instruction with the exception flag set and the write enable high sets its destination tag and raises no request.
- R3: A speculative, non-store, non-check instruction with either source tagged sets its destination tag (when written) and raises no request.
- R4: A non-speculative, non-store, non-check instruction with both sources clean and no exception clears its destination tag (when written) and raises no request.
- R5: A non-speculative, non-store, non-check instruction with a tagged source raises a fault request and leaves the tags unchanged. The reported index is source A if A is tagged, otherwise source B.
- R6: A non-speculative, non-store, non-check instruction with clean sources and the exception flag set raises a fault request reporting its destination number, and leaves the tags unchanged.
- R7: A store raises a fault request when its address register (source A) or its data register (source B) is tagged, reporting A before B. Its speculative flag is ignored, and it never changes any tag.
- R8: A check instruction raises a recovery request reporting source A when that register is tagged, and nothing otherwise. It never faults and never changes a tag. The check flag takes priority over the store flag, and the store flag over the other instruction forms.
- R9: Register 0 is never tagged, whatever is written to it.
- R10: A request appears only in the cycle after the clock edge that accepted a valid instruction, lasts one cycle, and fault and recovery are never raised together. A cycle with `ins_vld` low changes nothing.
- R11: With the write enable low, a non-store, non-check instruction changes no tag.
- R12: An instruction sees the tag written by the instruction accepted in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_vld | input | 1 | Descriptor valid this cycle |
| ins_src_a | input | 5 | Source A index (store address, checked register) |
| ins_src_b | input | 5 | Source B index (store data) |
| ins_dst | input | 5 | Destination index |
| ins_dst_wr | input | 1 | Destination write enable |
| ins_spec | input | 1 | Instruction was issued speculatively |
| ins_exc | input | 1 | Instruction suffered a terminating exception |
| ins_store | input | 1 | Instruction is a store |
| ins_check | input | 1 | Instruction is a speculation check |
| fault_req | output | 1 | One-cycle terminating fault request |
| recover_req | output | 1 | One-cycle branch-to-recovery request |
| req_reg_idx | output | 5 | Register index that caused the request |
| tag_state | output | 32 | Current tag bit of every register |

## Verification
The assertions check on every cycle that register 0 stays clean and that requests appear only after accepted instructions, one at a time. They also check that stores and checks leave the tags untouched, that a speculative exception tags its destination, that a non-speculative consumer of a tagged value faults, and that a check on a tagged register requests recovery with its index. Only the bench's scenarios can show the following: the A-before-B priority in the reported index, the priority of check over store over the plain forms, the effect of a low write enable, back-to-back propagation of a freshly set tag into the next instruction, and the clearing of all tags by an asynchronous reset in the middle of a run.

// File: rtl/poison_pkg.sv
package poison_pkg;

  typedef enum logic [1:0] {
    OPK_PLAIN = 2'd0,
    OPK_STORE = 2'd1,
    OPK_CHECK = 2'd2
  } op_kind_e;

  // check outranks store, store outranks the plain forms
  function automatic op_kind_e classify(input logic is_store, input logic is_check);
    if (is_check)      return OPK_CHECK;
    else if (is_store) return OPK_STORE;
    else               return OPK_PLAIN;
  endfunction

endpackage

// File: rtl/poison_rst_sync.sv
module poison_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;

endmodule

// File: rtl/poison_tag_file.sv
module poison_tag_file #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic             rd_a,
  output logic             rd_b,
  output logic [NREG-1:0]  tags_o
);

  logic [NREG-1:0] tag_q;
  logic [NREG-1:0] tag_en;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic tag_nx;

    always_comb begin
      tag_en[g] = wr_en && (wr_idx == IDX_W'(g));
      tag_nx    = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= 1'b0;
      end else if (tag_en[g]) begin
        tag_q[g] <= tag_nx;
      end
    end
  end

  assign rd_a   = tag_q[rd_a_idx];
  assign rd_b   = tag_q[rd_b_idx];
  assign tags_o = tag_q;

  // R9
  zero_reg_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_q[0]);

endmodule

// File: rtl/poison_decide.sv
module poison_decide
  import poison_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             vld,
  input  op_kind_e         kind,
  input  logic             spec,
  input  logic             exc,
  input  logic             dst_wr,
  input  logic [IDX_W-1:0] dst,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic             tag_a,
  input  logic             tag_b,
  output logic             wr_en,
  output logic             wr_val,
  output logic             fault_nx,
  output logic             recover_nx,
  output logic [IDX_W-1:0] idx_nx
);

  logic             any_src;
  logic [IDX_W-1:0] first_src;
  logic             dst_ok;

  always_comb begin
    any_src   = tag_a | tag_b;
    first_src = tag_a ? src_a : src_b;
    dst_ok    = dst_wr && (dst != '0);
  end

  always_comb begin
    wr_en      = 1'b0;
    wr_val     = 1'b0;
    fault_nx   = 1'b0;
    recover_nx = 1'b0;
    idx_nx     = '0;
    if (vld) begin
      unique case (kind)
        OPK_CHECK: begin
          if (tag_a) begin
            recover_nx = 1'b1;
            idx_nx     = src_a;
          end
        end
        OPK_STORE: begin
          if (any_src) begin
            fault_nx = 1'b1;
            idx_nx   = first_src;
          end
        end
        default: begin
          if (spec) begin
            wr_en  = dst_ok;
            wr_val = any_src | exc;
          end else if (any_src) begin
            fault_nx = 1'b1;
            idx_nx   = first_src;
          end else if (exc) begin
            fault_nx = 1'b1;
            idx_nx   = dst;
          end else begin
            wr_en  = dst_ok;
            wr_val = 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/poison_req_reg.sv
module poison_req_reg #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             fault_nx,
  input  logic             recover_nx,
  input  logic [IDX_W-1:0] idx_nx,
  output logic             fault_q,
  output logic             recover_q,
  output logic [IDX_W-1:0] idx_q
);

  logic             fault_d;
  logic             recover_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    fault_d   = fault_nx;
    recover_d = recover_nx;
    idx_d     = (fault_nx | recover_nx) ? idx_nx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q   <= 1'b0;
      recover_q <= 1'b0;
      idx_q     <= '0;
    end else begin
      fault_q   <= fault_d;
      recover_q <= recover_d;
      idx_q     <= idx_d;
    end
  end

  // R10
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_q, recover_q}));

  // R10
  request_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q | recover_q) |-> $past(vld_i));

endmodule

// File: rtl/poison_tracker.sv
module poison_tracker
  import poison_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_src_a,
  input  logic [IDX_W-1:0] ins_src_b,
  input  logic [IDX_W-1:0] ins_dst,
  input  logic             ins_dst_wr,
  input  logic             ins_spec,
  input  logic             ins_exc,
  input  logic             ins_store,
  input  logic             ins_check,
  output logic             fault_req,
  output logic             recover_req,
  output logic [IDX_W-1:0] req_reg_idx,
  output logic [NREG-1:0]  tag_state
);

  logic             rst_sync_n;
  op_kind_e         kind;
  logic             tag_a;
  logic             tag_b;
  logic             wr_en;
  logic             wr_val;
  logic             fault_nx;
  logic             recover_nx;
  logic [IDX_W-1:0] idx_nx;

  assign kind = classify(ins_store, ins_check);

  poison_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  poison_tag_file #(.NREG(NREG), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_idx   (ins_dst),
    .wr_val   (wr_val),
    .rd_a_idx (ins_src_a),
    .rd_b_idx (ins_src_b),
    .rd_a     (tag_a),
    .rd_b     (tag_b),
    .tags_o   (tag_state)
  );

  poison_decide #(.IDX_W(IDX_W)) u_decide (
    .vld        (ins_vld),
    .kind       (kind),
    .spec       (ins_spec),
    .exc        (ins_exc),
    .dst_wr     (ins_dst_wr),
    .dst        (ins_dst),
    .src_a      (ins_src_a),
    .src_b      (ins_src_b),
    .tag_a      (tag_a),
    .tag_b      (tag_b),
    .wr_en      (wr_en),
    .wr_val     (wr_val),
    .fault_nx   (fault_nx),
    .recover_nx (recover_nx),
    .idx_nx     (idx_nx)
  );

  poison_req_reg #(.IDX_W(IDX_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .vld_i      (ins_vld),
    .fault_nx   (fault_nx),
    .recover_nx (recover_nx),
    .idx_nx     (idx_nx),
    .fault_q    (fault_req),
    .recover_q  (recover_req),
    .idx_q      (req_reg_idx)
  );

  // R2
  spec_exc_tags_dst_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && !ins_check && !ins_store && ins_spec && ins_exc && ins_dst_wr
     && (ins_dst != '0))
    |=> (tag_state[$past(ins_dst)] && !fault_req && !recover_req));

  // R5
  nonspec_poison_faults_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && !ins_check && !ins_store && !ins_spec
     && (tag_state[ins_src_a] || tag_state[ins_src_b]))
    |=> (fault_req && $stable(tag_state)));

  // R7
  store_keeps_tags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && ins_store && !ins_check) |=> (!recover_req && $stable(tag_state)));

  // R8
  check_recovers_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ins_vld && ins_check && tag_state[ins_src_a])
    |=> (recover_req && !fault_req && (req_reg_idx == $past(ins_src_a))
         && $stable(tag_state)));

endmodule

// File: tb/poison_tracker_tb.sv
module poison_tracker_tb_top;

  localparam int NREG  = 32;
  localparam int IDX_W = 5;
  localparam int NVEC  = 18;

  typedef struct packed {
    logic [4:0] a;
    logic [4:0] b;
    logic [4:0] d;
    logic [4:0] fl;   // {dst_wr, spec, exc, store, check}
    logic       ef;
    logic       er;
    logic [4:0] eidx;
    logic [7:0] etag;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{5'd1, 5'd2, 5'd3, 5'b11100, 1'b0, 1'b0, 5'd0, 8'h08},
    '{5'd3, 5'd0, 5'd4, 5'b11000, 1'b0, 1'b0, 5'd0, 8'h18},
    '{5'd0, 5'd4, 5'd5, 5'b11000, 1'b0, 1'b0, 5'd0, 8'h38},
    '{5'd1, 5'd3, 5'd6, 5'b10000, 1'b1, 1'b0, 5'd3, 8'h38},
    '{5'd4, 5'd5, 5'd6, 5'b10000, 1'b1, 1'b0, 5'd4, 8'h38},
    '{5'd1, 5'd2, 5'd4, 5'b10000, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd1, 5'd2, 5'd7, 5'b10100, 1'b1, 1'b0, 5'd7, 8'h28},
    '{5'd5, 5'd1, 5'd0, 5'b01010, 1'b1, 1'b0, 5'd5, 8'h28},
    '{5'd1, 5'd3, 5'd0, 5'b00010, 1'b1, 1'b0, 5'd3, 8'h28},
    '{5'd1, 5'd2, 5'd0, 5'b00010, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd3, 5'd0, 5'd0, 5'b00001, 1'b0, 1'b1, 5'd3, 8'h28},
    '{5'd2, 5'd0, 5'd0, 5'b00001, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd5, 5'd0, 5'd1, 5'b11111, 1'b0, 1'b1, 5'd5, 8'h28},
    '{5'd1, 5'd2, 5'd0, 5'b11100, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd3, 5'd0, 5'd0, 5'b11000, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd1, 5'd2, 5'd1, 5'b01100, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd1, 5'd2, 5'd3, 5'b00000, 1'b0, 1'b0, 5'd0, 8'h28},
    '{5'd1, 5'd2, 5'd3, 5'b10000, 1'b0, 1'b0, 5'd0, 8'h20}
  };

  logic             clk;
  logic             rst_n;
  logic             ins_vld;
  logic [IDX_W-1:0] ins_src_a;
  logic [IDX_W-1:0] ins_src_b;
  logic [IDX_W-1:0] ins_dst;
  logic             ins_dst_wr;
  logic             ins_spec;
  logic             ins_exc;
  logic             ins_store;
  logic             ins_check;
  logic             fault_req;
  logic             recover_req;
  logic [IDX_W-1:0] req_reg_idx;
  logic [NREG-1:0]  tag_state;

  int checks = 0;
  int errors = 0;

  poison_tracker #(.NREG(NREG), .IDX_W(IDX_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_vld     (ins_vld),
    .ins_src_a   (ins_src_a),
    .ins_src_b   (ins_src_b),
    .ins_dst     (ins_dst),
    .ins_dst_wr  (ins_dst_wr),
    .ins_spec    (ins_spec),
    .ins_exc     (ins_exc),
    .ins_store   (ins_store),
    .ins_check   (ins_check),
    .fault_req   (fault_req),
    .recover_req (recover_req),
    .req_reg_idx (req_reg_idx),
    .tag_state   (tag_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string row_req(input int i);
    case (i)
      0:              return "R2";
      1:              return "R3/R12";
      2:              return "R3";
      3, 4:           return "R5";
      5, 17:          return "R4";
      6:              return "R6";
      7, 8, 9:        return "R7";
      10, 11, 12:     return "R8";
      13, 14:         return "R9";
      default:        return "R11";
    endcase
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    ins_vld = 1'b0; ins_src_a = '0; ins_src_b = '0; ins_dst = '0;
    ins_dst_wr = 1'b0; ins_spec = 1'b0; ins_exc = 1'b0;
    ins_store = 1'b0; ins_check = 1'b0;
  endtask

  task automatic drive_vec(input vec_t v);
    ins_vld    = 1'b1;
    ins_src_a  = v.a;
    ins_src_b  = v.b;
    ins_dst    = v.d;
    ins_dst_wr = v.fl[4];
    ins_spec   = v.fl[3];
    ins_exc    = v.fl[2];
    ins_store  = v.fl[1];
    ins_check  = v.fl[0];
  endtask

  task automatic check_vec(input int i);
    string r;
    r = row_req(i);
    check_eq(r, "fault_req", 32'(fault_req), 32'(VECS[i].ef));
    check_eq(r, "recover_req", 32'(recover_req), 32'(VECS[i].er));
    if (VECS[i].ef || VECS[i].er)
      check_eq(r, "req_reg_idx", 32'(req_reg_idx), 32'(VECS[i].eidx));
    check_eq(r, "tag_state", tag_state, {24'h0, VECS[i].etag});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check_eq("R1", "tag_state in reset", tag_state, 32'h0);
    check_eq("R1", "requests in reset", {30'h0, fault_req, recover_req}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "tag_state after release", tag_state, 32'h0);

    // table walk, one descriptor per cycle back to back
    for (int i = 0; i < NVEC; i++) begin
      drive_vec(VECS[i]);
      @(negedge clk);
      if (i == NVEC - 1) drive_idle();
      check_vec(i);
    end

    // R10: request lasts one cycle, idle cycle raises nothing
    @(negedge clk);
    check_eq("R10", "idle requests", {30'h0, fault_req, recover_req}, 32'h0);

    // R10: invalid descriptor that would fault and tag is ignored
    ins_vld = 1'b0; ins_store = 1'b1; ins_src_a = 5'd5;
    @(negedge clk);
    ins_store = 1'b0; ins_spec = 1'b1; ins_exc = 1'b1; ins_dst_wr = 1'b1; ins_dst = 5'd9;
    @(negedge clk);
    check_eq("R10", "invalid requests", {30'h0, fault_req, recover_req}, 32'h0);
    check_eq("R10", "invalid tag_state", tag_state, 32'h20);
    drive_idle();

    // R7: store through a clean address with tagged data reports B
    ins_vld = 1'b1; ins_store = 1'b1; ins_src_a = 5'd2; ins_src_b = 5'd5;
    @(negedge clk);
    drive_idle();
    check_eq("R7", "store data fault", 32'(fault_req), 32'h1);
    check_eq("R7", "store data idx", 32'(req_reg_idx), 32'd5);

    // R1: asynchronous reset in mid-run clears every tag at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_eq("R1", "tag_state async clear", tag_state, 32'h0);
    check_eq("R1", "requests async clear", {30'h0, fault_req, recover_req}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule